// File: doc/BRIEF.md
# Coincidence Window Time Averager

This block sits between the per-stave trigger sources and the global trigger. Each incoming pulse carries a trigger time and the index of the stave that produced it. The first pulse of an event opens a coincidence window of programmable length. Pulses from other staves that arrive while the window is open belong to the same event. When the window closes, the block emits one event-time estimate together with the number of staves that contributed to it.

Two combination modes are selected by a mode input, which is sampled when an event opens. In averaging mode the estimate is the arithmetic mean of the grouped times. There is no divider: the sum is multiplied by a fixed reciprocal constant chosen by the hit count, then rounded and shifted. In first-hit mode the opening pulse is forwarded at once, and every later pulse inside the window is masked so that the global trigger sees one trigger per event.

Top module: `coinc_time_avg`

## Requirements
- R1: After reset `out_valid` is 0 and `out_hits` is 0, and no output appears until a pulse arrives.
- R2: Let L be `win_len`, with values below 2 treated as 2. A pulse that arrives 1 to L-1 cycles after the opening pulse joins its event. The window closes in the cycle that lies L cycles after the opening pulse.
- R3: A pulse that arrives in the closing cycle of a window is not dropped. It opens a new event at once.
- R4: In averaging mode, each event yields exactly one output, in the cycle after its window closes. `out_hits` equals the number of distinct contributing staves. `out_time` is within 1 LSB of the mean rounded half-up, that is (2*sum+n)/(2*n) in integer arithmetic.
- R5: In averaging mode an event with a single hit outputs that hit's time exactly, with `out_hits` = 1.
- R6: The reciprocal scaling covers every hit count from 1 to the stave count. This includes the non-power-of-two counts 3, 5, 7, 11 and 13.
- R7: In first-hit mode the opening pulse appears on the output in the next cycle, with its own time and `out_hits` = 1.
- R8: In first-hit mode no further output appears for pulses inside that event's window, and the window's closing produces no output.
- R9: A repeated pulse from a stave already in the open event is ignored. The stave is counted once, and the time of its first pulse is the one used.
- R10: `avg_mode` (1 = averaging, 0 = first-hit) is sampled only by the opening pulse of an event. Changing it mid-window has no effect on that event.
- R11: Sometimes an averaging event closes in the same cycle that a new event opens in first-hit mode. In that case the averaged result is emitted first, and the first-hit forward follows one cycle later.
- R12: Up to 16 staves, indices 0 to 15, can contribute to one event. With all of them present, `out_hits` = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_mode | input | 1 | 1 = averaging, 0 = first-hit forwarding; sampled at event open |
| win_len | input | WIN_W (8) | Coincidence window length in cycles (minimum effective 2) |
| in_valid | input | 1 | Trigger pulse present |
| in_time | input | TIME_W (16) | Trigger time of the pulse |
| in_stave | input | log2(STAVES) (4) | Index of the originating stave |
| out_valid | output | 1 | Event estimate present (one cycle) |
| out_time | output | TIME_W (16) | Estimated event time |
| out_hits | output | log2(STAVES+1) (5) | Number of contributing staves |

## Verification
Two functions can fall in the same cycle. The first is the closing of a window with its averaged output. The second is the arrival of a pulse that opens the next event, either in averaging mode or in first-hit mode, which needs the output port at the same moment. Directed sequences place a pulse exactly in the closing cycle in both modes. The random phase keeps hitting this case with short windows and dense traffic. The reference model predicts that the averaged result comes first, that the new event starts with a fresh hit count and stave set, and that the delayed forward follows one cycle later. Any lost, merged or misordered output is reported.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

    typedef enum logic {
        MODE_FIRST = 1'b0,
        MODE_AVG   = 1'b1
    } mode_e;

    // Rounded fixed-point reciprocal 2^sh / n
    function automatic logic [63:0] recip_const(input int sh, input int n);
        logic [63:0] one_sh;
        one_sh = 64'd1 << sh;
        return (one_sh + 64'(n / 2)) / 64'(n);
    endfunction

endpackage

// File: rtl/coinc_win_timer.sv
module coinc_win_timer #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIN_W-1:0] win_len,
    output logic             open,
    output logic [WIN_W-1:0] cnt,
    output logic             close
);
    localparam logic [WIN_W-1:0] MIN_LEN = WIN_W'(2);

    typedef struct packed {
        logic             open;
        logic [WIN_W-1:0] cnt;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [WIN_W-1:0] eff_len;

    always_comb begin
        eff_len = (win_len < MIN_LEN) ? MIN_LEN : win_len;
        close   = tmr_q.open && (tmr_q.cnt >= eff_len);
        tmr_d   = tmr_q;
        if (start) begin
            tmr_d.open = 1'b1;
            tmr_d.cnt  = WIN_W'(1);
        end else if (close) begin
            tmr_d.open = 1'b0;
        end else if (tmr_q.open) begin
            tmr_d.cnt = tmr_q.cnt + WIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign open = tmr_q.open;
    assign cnt  = tmr_q.cnt;

endmodule

// File: rtl/coinc_recip_mul.sv
module coinc_recip_mul #(
    parameter int SUM_W = 21,
    parameter int HIT_W = 5,
    parameter int MAXN  = 16,
    parameter int OUT_W = 16
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [HIT_W-1:0] n,
    output logic [OUT_W-1:0] mean
);
    localparam int SH = SUM_W + 1;
    localparam int RW = SH + 1;
    localparam int PW = SUM_W + RW;

    logic [RW-1:0] recip_tbl [MAXN+1];
    logic [RW-1:0] recip_sel;
    logic [PW-1:0] prod;

    for (genvar g = 0; g <= MAXN; g++) begin : g_tbl
        if (g == 0) begin : g_zero
            assign recip_tbl[g] = '0;
        end else begin : g_val
            assign recip_tbl[g] = RW'(coinc_pkg::recip_const(SH, g));
        end
    end

    always_comb begin
        recip_sel = (n > HIT_W'(MAXN)) ? '0 : recip_tbl[n];
        prod      = PW'(sum) * PW'(recip_sel) + (PW'(1) << (SH - 1));
        mean      = prod[SH +: OUT_W];
    end

endmodule

// File: rtl/coinc_time_avg.sv
module coinc_time_avg #(
    parameter int TIME_W = 16,
    parameter int STAVES = 16,
    parameter int WIN_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       avg_mode,
    input  logic [WIN_W-1:0]           win_len,
    input  logic                       in_valid,
    input  logic [TIME_W-1:0]          in_time,
    input  logic [$clog2(STAVES)-1:0]  in_stave,
    output logic                       out_valid,
    output logic [TIME_W-1:0]          out_time,
    output logic [$clog2(STAVES+1)-1:0] out_hits
);
    import coinc_pkg::*;

    localparam int HIT_W = $clog2(STAVES + 1);
    localparam int SUM_W = TIME_W + HIT_W;

    typedef struct packed {
        logic [STAVES-1:0] seen;
        logic [SUM_W-1:0]  sum;
        logic [HIT_W-1:0]  n;
        logic              ev_avg;
        logic              pend;
        logic [TIME_W-1:0] pend_t;
        logic              ov;
        logic [TIME_W-1:0] ot;
        logic [HIT_W-1:0]  oh;
    } ev_t;

    ev_t               ev_d, ev_q;
    logic              win_open, win_close, accept, grp, new_avg;
    logic [WIN_W-1:0]  win_cnt;
    logic [TIME_W-1:0] mean;

    coinc_win_timer #(.WIN_W(WIN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .win_len (win_len),
        .open    (win_open),
        .cnt     (win_cnt),
        .close   (win_close)
    );

    coinc_recip_mul #(
        .SUM_W (SUM_W),
        .HIT_W (HIT_W),
        .MAXN  (STAVES),
        .OUT_W (TIME_W)
    ) u_scale (
        .sum  (ev_q.sum),
        .n    (ev_q.n),
        .mean (mean)
    );

    always_comb begin
        new_avg = (mode_e'(avg_mode) == MODE_AVG);
        accept  = in_valid && (!win_open || win_close);
        grp     = in_valid && win_open && !win_close && !ev_q.seen[in_stave];

        ev_d      = ev_q;
        ev_d.ov   = 1'b0;
        ev_d.pend = 1'b0;

        // output arbitration: averaged close, then delayed forward, then direct forward
        if (win_close && ev_q.ev_avg) begin
            ev_d.ov = 1'b1;
            ev_d.ot = mean;
            ev_d.oh = ev_q.n;
            if (accept && !new_avg) begin
                ev_d.pend   = 1'b1;
                ev_d.pend_t = in_time;
            end
        end else if (ev_q.pend) begin
            ev_d.ov = 1'b1;
            ev_d.ot = ev_q.pend_t;
            ev_d.oh = HIT_W'(1);
        end else if (accept && !new_avg) begin
            ev_d.ov = 1'b1;
            ev_d.ot = in_time;
            ev_d.oh = HIT_W'(1);
        end

        // event accumulation
        if (accept) begin
            ev_d.seen           = '0;
            ev_d.seen[in_stave] = 1'b1;
            ev_d.sum            = SUM_W'(in_time);
            ev_d.n              = HIT_W'(1);
            ev_d.ev_avg         = new_avg;
        end else if (grp) begin
            ev_d.seen[in_stave] = 1'b1;
            ev_d.sum            = ev_q.sum + SUM_W'(in_time);
            ev_d.n              = ev_q.n + HIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign out_valid = ev_q.ov;
    assign out_time  = ev_q.ot;
    assign out_hits  = ev_q.oh;

    logic [STAVES-1:0] seen_mask;
    logic [HIT_W-1:0]  hit_cnt;
    logic              ev_avg_q;
    logic              pend_q;
    assign seen_mask = ev_q.seen;
    assign hit_cnt   = ev_q.n;
    assign ev_avg_q  = ev_q.ev_avg;
    assign pend_q    = ev_q.pend;

endmodule

// File: rtl/coinc_time_avg_chk.sv
module coinc_time_avg_chk #(
    parameter int STAVES = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        out_valid,
    input logic [$clog2(STAVES+1)-1:0] out_hits,
    input logic                        win_open,
    input logic                        win_close,
    input logic [STAVES-1:0]           seen_mask,
    input logic [$clog2(STAVES+1)-1:0] hit_cnt,
    input logic                        ev_avg_q,
    input logic                        pend_q
);
    localparam int HIT_W = $clog2(STAVES + 1);

    // R12
    hits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hits != '0) && (out_hits <= HIT_W'(STAVES)));

    // R9
    seen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> ($countones(seen_mask) == 32'(hit_cnt)));

    // R4
    avg_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_close && ev_avg_q) |=> (out_valid && out_hits == $past(hit_cnt)));

    // R11
    pend_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (out_valid && out_hits == HIT_W'(1)));

    // R8
    first_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !win_close && !ev_avg_q && !pend_q) |=> !out_valid);

    // R7
    first_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(win_close && ev_avg_q)) |-> (out_hits == HIT_W'(1)));

endmodule

bind coinc_time_avg coinc_time_avg_chk #(.STAVES(STAVES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_hits  (out_hits),
    .win_open  (win_open),
    .win_close (win_close),
    .seen_mask (seen_mask),
    .hit_cnt   (hit_cnt),
    .ev_avg_q  (ev_avg_q),
    .pend_q    (pend_q)
);

// File: tb/coinc_time_avg_tb.sv
`timescale 1ns/1ps
module coinc_time_avg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        avg_mode = 1'b1;
    logic [7:0]  win_len = 8'd4;
    logic        in_valid = 1'b0;
    logic [15:0] in_time = '0;
    logic [3:0]  in_stave = '0;
    logic        out_valid;
    logic [15:0] out_time;
    logic [4:0]  out_hits;

    int checks = 0;
    int fails  = 0;
    string phase_tag = "R1";

    always #2.5 clk = ~clk;

    coinc_time_avg u_dut (
        .clk(clk), .rst_n(rst_n), .avg_mode(avg_mode), .win_len(win_len),
        .in_valid(in_valid), .in_time(in_time), .in_stave(in_stave),
        .out_valid(out_valid), .out_time(out_time), .out_hits(out_hits)
    );

    // spec model state
    bit          m_open = 0;
    int          m_cnt = 0;
    bit [15:0]   m_seen = '0;
    longint      m_sum = 0;
    int          m_n = 0;
    bit          m_avg = 0;
    bit          m_pend = 0;
    int          m_pend_t = 0;
    // expectation for the current edge
    bit          e_v;
    int          e_t;
    int          e_h;
    bit          e_exact;
    string       e_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int round_mean(input longint s, input int n);
        return int'((2 * s + n) / (2 * n));
    endfunction

    task automatic model_edge(input bit v, input int t, input int s, input bit m);
        int  eff;
        bit  cls, acc, grp;
        eff = (int'(win_len) < 2) ? 2 : int'(win_len);
        cls = m_open && (m_cnt >= eff);
        acc = v && (!m_open || cls);
        grp = v && m_open && !cls && !m_seen[s];
        e_v = 0; e_exact = 1; e_t = 0; e_h = 0; e_tag = phase_tag;
        if (cls && m_avg) begin
            e_v = 1; e_h = m_n; e_t = round_mean(m_sum, m_n);
            e_exact = (m_n == 1);
            e_tag = (m_n == 1) ? "R5" : ((m_n == 16) ? "R12" : "R4");
        end else if (m_pend) begin
            e_v = 1; e_h = 1; e_t = m_pend_t; e_tag = "R11";
        end else if (acc && !m) begin
            e_v = 1; e_h = 1; e_t = t; e_tag = "R7";
        end
        m_pend = cls && m_avg && acc && !m;
        if (m_pend) m_pend_t = t;
        if (acc) begin
            m_open = 1; m_cnt = 1; m_seen = '0; m_seen[s] = 1;
            m_sum = t; m_n = 1; m_avg = m;
        end else begin
            if (cls) m_open = 0;
            else if (m_open) m_cnt++;
            if (grp) begin
                m_seen[s] = 1; m_sum += t; m_n++;
            end
        end
    endtask

    task automatic step(input bit v, input int t, input int s, input bit m);
        in_valid = v; in_time = 16'(t); in_stave = 4'(s); avg_mode = m;
        @(posedge clk);
        model_edge(v, t, s, m);
        @(negedge clk);
        chk(out_valid === e_v, e_tag, "out_valid", longint'(out_valid), longint'(e_v));
        if (e_v && out_valid) begin
            chk(int'(out_hits) == e_h, e_tag, "out_hits", out_hits, e_h);
            if (e_exact)
                chk(int'(out_time) == e_t, e_tag, "out_time", out_time, e_t);
            else
                chk((int'(out_time) - e_t <= 1) && (e_t - int'(out_time) <= 1),
                    e_tag, "out_time(+-1)", out_time, e_t);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, avg_mode);
    endtask

    // averaging burst over n distinct staves, one per cycle
    task automatic burst(input int n, input bit big);
        win_len = 8'(n + 2);
        for (int i = 0; i < n; i++)
            step(1, big ? 65535 - int'($urandom % 8) : int'($urandom % 65536), i, 1);
        idle(n + 4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_hits == 5'd0, "R1", "out_hits after reset", out_hits, 0);
        phase_tag = "R1"; idle(3);

        // R5: single hit exact
        phase_tag = "R2"; win_len = 8'd3;
        step(1, 54321, 7, 1); idle(5);
        // R6: every count, incl. 3,5,7,11,13; R12 full 16
        for (int n = 2; n <= 16; n++) burst(n, 0);
        burst(16, 1); burst(13, 1); burst(11, 0); burst(7, 0);

        // R9: duplicate stave ignored, first time kept
        phase_tag = "R9"; win_len = 8'd8;
        step(1, 1000, 3, 1); step(1, 10, 3, 1); step(1, 2000, 5, 1); step(1, 40000, 3, 1);
        idle(10);

        // R2 / R3: pulse in closing cycle opens new event
        phase_tag = "R3"; win_len = 8'd4;
        step(1, 100, 1, 1); idle(2); step(1, 300, 2, 1); step(1, 900, 4, 1);
        idle(8);
        // R2: win_len below 2 treated as 2
        phase_tag = "R2"; win_len = 8'd0;
        step(1, 500, 1, 1); step(1, 700, 2, 1); step(1, 9000, 3, 1); idle(6);

        // R7 / R8: first-hit forward and masking
        phase_tag = "R8"; win_len = 8'd6;
        step(1, 4242, 9, 0); step(1, 1, 2, 0); step(1, 2, 3, 0); idle(2);
        step(1, 77, 4, 0); step(1, 88, 5, 0); idle(8);

        // R10: mode change mid-window ignored
        phase_tag = "R10"; win_len = 8'd5;
        step(1, 1200, 0, 1); step(1, 1300, 1, 0); step(1, 1400, 2, 0); idle(8);
        step(1, 600, 0, 0); step(1, 700, 1, 1); idle(8);

        // R11: averaging close collides with first-hit open
        phase_tag = "R11"; win_len = 8'd3;
        step(1, 111, 0, 1); step(1, 333, 1, 1); idle(1); step(1, 5555, 2, 0);
        idle(6);

        // random phase
        phase_tag = "R8";
        for (int c = 0; c < 6000; c++) begin
            if (c % 250 == 0) win_len = 8'($urandom % 12);
            if (c % 400 == 0) avg_mode = 1'($urandom % 2);
            step(($urandom % 3) == 0, int'($urandom % 65536), int'($urandom % 16),
                 (($urandom % 20) == 0) ? ~avg_mode : avg_mode);
        end
        idle(20);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule